// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small CPU core, its main oscillator and its peripheral clocks run. Two one-cycle instruction strobes ask for a sleep: the lighter one stops only the CPU clock and leaves the timers counting with their state kept. The deeper one stops everything, the oscillator included. Interrupt requests arrive one bit per source, with a per-source enable and a per-source flag that marks the source as a port (pin-change) interrupt.

Wake-up depends on the sleep depth. From the light sleep any enabled interrupt returns the core to running at once. From the deep sleep only an enabled port interrupt is accepted. The oscillator is then restarted, the CPU clock stays gated for a fixed settle time, and the watchdog gets a clear pulse. Every return to running raises a one-cycle wake event, which the core uses to enter the interrupt service routine before it resumes after the sleep instruction. A low-voltage input forces the deep sleep from any state and holds it there for as long as it is asserted.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller returns to running (`mode` = 0), with all three clock enables high and both pulse outputs low.
- R2: A `halt_req` in the running state moves the controller to light sleep (`mode` = 1) at the next edge: CPU clock off, oscillator and peripheral clocks on.
- R3: A `stop_req` in the running state moves the controller to deep sleep (`mode` = 2) at the next edge with all three enables off. When both strobes arrive in the same cycle, `stop_req` wins.
- R4: In light sleep, a source i with `irq_req[i]` and `irq_en[i]` both high returns the controller to running at the next edge. A request whose enable is low has no effect.
- R5: In deep sleep, only a source with `irq_req[i]`, `irq_en[i]` and `irq_port[i]` all high causes a wake. Any other request leaves the controller in deep sleep with all enables off.
- R6: `wdt_clr` is high for exactly one cycle: the first cycle of the settle state (`mode` = 3) that follows deep sleep. It is never high at any other time.
- R7: The settle state lasts exactly `SETTLE_CYC` cycles, with the oscillator on and the CPU and peripheral clocks off. After it, the controller is running.
- R8: `lv_force_stop` high at an edge puts the controller in deep sleep from any state. While it stays high, port interrupts cannot wake the controller.
- R9: `wake_evt` is high for exactly one cycle: the first running cycle after light sleep or after settle.
- R10: `halt_req` and `stop_req` have no effect outside the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Light-sleep instruction strobe |
| stop_req | input | 1 | Deep-sleep instruction strobe |
| lv_force_stop | input | 1 | Low-voltage force into deep sleep |
| irq_req | input | N_IRQ | Interrupt request per source |
| irq_en | input | N_IRQ | Interrupt enable per source |
| irq_port | input | N_IRQ | Marks a source as a port interrupt |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | 1 | Peripheral/timer clock enable |
| wdt_clr | output | 1 | Watchdog clear pulse on wake from deep sleep |
| wake_evt | output | 1 | One-cycle wake event toward the interrupt entry |
| mode | output | 2 | Current state: 0 run, 1 light sleep, 2 deep sleep, 3 settle |

## Verification
The bench builds the block with `N_IRQ` = 4 and `SETTLE_CYC` = 3. Four sources are enough for mixed patterns: a port source next to non-port sources, and enabled sources next to disabled ones, so the deep-sleep filter is tested against requests that would wake the light sleep. A three-cycle settle window is short enough that every cycle of it can be checked one by one. The bench checks the exact cycle of the return to running, the single `wdt_clr` cycle at the start of the window, and a low-voltage force that cuts the window short.

// File: rtl/pmc_pkg.sv
// Package: shared state encoding for the low-power mode sequencer.
// Assumes: the encoding is visible at the top-level `mode` port and is
// therefore part of the block's interface.
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_HALT   = 2'd1,
        PM_STOP   = 2'd2,
        PM_SETTLE = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pmc_wake_qual.sv
// Module: pmc_wake_qual
// Forms the two wake conditions from the per-source interrupt inputs:
// any enabled request (for light sleep) and any enabled port request
// (for deep sleep). Purely combinational.
// Assumes: the request inputs are already synchronous to clk.
module pmc_wake_qual #(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_port,
    output logic             any_wake,
    output logic             port_wake
);
    logic [N_IRQ-1:0] qual_any;
    logic [N_IRQ-1:0] qual_port;

    // Per-source qualification of each request.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_src
        assign qual_any[g]  = irq_req[g] & irq_en[g];
        assign qual_port[g] = irq_req[g] & irq_en[g] & irq_port[g];
    end

    // Reduce the per-source terms into the two wake conditions.
    always_comb begin
        any_wake  = |qual_any;
        port_wake = |qual_port;
    end

    // R5: a port wake is always also a general wake.
    always_comb begin
        a_r5_port_subset: assert (!port_wake || any_wake)
            else $error("port wake without general wake");
    end
endmodule

// File: rtl/pmc_settle_timer.sv
// Module: pmc_settle_timer
// Down-counter that times the oscillator settle window. `load` starts a
// window of SETTLE_CYC cycles. `done` is high in the window's last cycle.
// Assumes: SETTLE_CYC >= 1, and `load` is given in the cycle before the
// window starts.
module pmc_settle_timer #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    // Load at the start of a window and count down while it is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The window ends in the cycle where the count reaches zero.
    always_comb done = (cnt == '0);

    // R7: the count never goes past the window length.
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD_VAL)
        else $error("settle count out of range");

    // R7: while counting, the count steps down by exactly one.
    a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1))
        else $error("settle count skipped");
endmodule

// File: rtl/pmc_seq.sv
// Module: pmc_seq
// Mode state machine. It moves between run, light sleep, deep sleep and
// settle, starts the settle timer, and registers the one-cycle
// watchdog-clear and wake pulses.
// Assumes: the instruction strobes last one cycle, and the wake terms
// come from pmc_wake_qual in the same cycle.
module pmc_seq
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_req,
    input  logic      stop_req,
    input  logic      lv_force_stop,
    input  logic      any_wake,
    input  logic      port_wake,
    input  logic      settle_done,
    output pm_state_e state,
    output logic      settle_load,
    output logic      settle_run,
    output logic      wdt_clr,
    output logic      wake_evt
);
    pm_state_e nxt;

    // Next-state choice; the low-voltage force wins over everything else.
    always_comb begin
        nxt = state;
        unique case (state)
            PM_RUN: begin
                if (lv_force_stop || stop_req) nxt = PM_STOP;
                else if (halt_req)             nxt = PM_HALT;
            end
            PM_HALT: begin
                if (lv_force_stop) nxt = PM_STOP;
                else if (any_wake) nxt = PM_RUN;
            end
            PM_STOP: begin
                if (!lv_force_stop && port_wake) nxt = PM_SETTLE;
            end
            PM_SETTLE: begin
                if (lv_force_stop)    nxt = PM_STOP;
                else if (settle_done) nxt = PM_RUN;
            end
            default: nxt = PM_RUN;
        endcase
    end

    // Timer control: load on leaving deep sleep, count while settling.
    always_comb begin
        settle_load = (state == PM_STOP) && (nxt == PM_SETTLE);
        settle_run  = (state == PM_SETTLE);
    end

    // State register and the registered one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PM_RUN;
            wdt_clr  <= 1'b0;
            wake_evt <= 1'b0;
        end else begin
            state    <= nxt;
            wdt_clr  <= settle_load;
            wake_evt <= (state != PM_RUN) && (nxt == PM_RUN);
        end
    end

    // R8: the low-voltage force always lands in deep sleep.
    a_r8_lv_forces_stop: assert property (@(posedge clk) disable iff (!rst_n)
        lv_force_stop |=> (state == PM_STOP))
        else $error("low-voltage force ignored");

    // R5: deep sleep is held unless a port interrupt qualifies.
    a_r5_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_STOP && !port_wake) |=> (state == PM_STOP))
        else $error("deep sleep left without port wake");

    // R6: the watchdog clear only follows deep sleep.
    a_r6_wdt_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_STOP && nxt == PM_SETTLE) |=> (wdt_clr && state == PM_SETTLE))
        else $error("watchdog clear missing on deep wake");

    // R9: the wake event is a single-cycle pulse in the running state.
    a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> (state == PM_RUN) ##1 !wake_evt)
        else $error("wake event malformed");

    // R3: the deep-sleep strobe beats the light-sleep strobe.
    a_r3_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && stop_req) |=> (state == PM_STOP))
        else $error("stop request lost");

    // R2: a lone light-sleep strobe reaches light sleep.
    a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && halt_req && !stop_req && !lv_force_stop) |=> (state == PM_HALT))
        else $error("halt request lost");
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Low-power mode sequencer: it joins the wake qualifier, the state
// machine and the settle timer, and decodes the clock enables from
// the state.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int SETTLE_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             stop_req,
    input  logic             lv_force_stop,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_port,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             periph_clk_en,
    output logic             wdt_clr,
    output logic             wake_evt,
    output logic [1:0]       mode
);
    logic      any_wake;
    logic      port_wake;
    logic      settle_done;
    logic      settle_load;
    logic      settle_run;
    pm_state_e state;

    pmc_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .irq_port (irq_port),
        .any_wake (any_wake),
        .port_wake(port_wake)
    );

    pmc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req     (halt_req),
        .stop_req     (stop_req),
        .lv_force_stop(lv_force_stop),
        .any_wake     (any_wake),
        .port_wake    (port_wake),
        .settle_done  (settle_done),
        .state        (state),
        .settle_load  (settle_load),
        .settle_run   (settle_run),
        .wdt_clr      (wdt_clr),
        .wake_evt     (wake_evt)
    );

    pmc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (settle_load),
        .run  (settle_run),
        .done (settle_done)
    );

    // Decode the clock enables from the current state.
    always_comb begin
        mode          = state;
        cpu_clk_en    = (state == PM_RUN);
        osc_en        = (state != PM_STOP);
        periph_clk_en = (state == PM_RUN) || (state == PM_HALT);
    end

    // R7: the CPU clock never runs while the oscillator is off.
    a_r7_cpu_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> osc_en)
        else $error("cpu clock without oscillator");
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int NI = 4;
    localparam int SC = 3;

    typedef struct packed {
        logic [3:0] rq;
        logic       h, s, lv;
        logic [3:0] irq, en, port;
        logic [1:0] md;
        logic       cpu, osc, per, wdt, wk;
    } vec_t;

    localparam int NV = 23;
    // Each row: requirement, inputs held for one cycle, expected outputs after the edge.
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b0,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd0, 1'b1,1'b1,1'b1,1'b0,1'b0}, // R1 idle run
        '{4'd2, 1'b1,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd1, 1'b0,1'b1,1'b1,1'b0,1'b0}, // R2 halt
        '{4'd4, 1'b0,1'b0,1'b0, 4'h1,4'h0,4'h0, 2'd1, 1'b0,1'b1,1'b1,1'b0,1'b0}, // R4 disabled ignored
        '{4'd10,1'b0,1'b1,1'b0, 4'h0,4'h0,4'h0, 2'd1, 1'b0,1'b1,1'b1,1'b0,1'b0}, // R10 stop in halt
        '{4'd4, 1'b0,1'b0,1'b0, 4'h1,4'h1,4'h0, 2'd0, 1'b1,1'b1,1'b1,1'b0,1'b1}, // R4 wake
        '{4'd9, 1'b0,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd0, 1'b1,1'b1,1'b1,1'b0,1'b0}, // R9 pulse ends
        '{4'd3, 1'b1,1'b1,1'b0, 4'h0,4'h0,4'h0, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 stop wins
        '{4'd5, 1'b0,1'b0,1'b0, 4'h2,4'hF,4'h1, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 non-port
        '{4'd5, 1'b0,1'b0,1'b0, 4'h1,4'h0,4'h1, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 disabled port
        '{4'd10,1'b1,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R10 halt in stop
        '{4'd6, 1'b0,1'b0,1'b0, 4'h1,4'hF,4'h1, 2'd3, 1'b0,1'b1,1'b0,1'b1,1'b0}, // R6 settle start
        '{4'd6, 1'b0,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0}, // R6 one cycle
        '{4'd7, 1'b1,1'b1,1'b0, 4'h0,4'h0,4'h0, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0}, // R7 third settle cycle
        '{4'd7, 1'b0,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd0, 1'b1,1'b1,1'b1,1'b0,1'b1}, // R7 back to run
        '{4'd9, 1'b0,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd0, 1'b1,1'b1,1'b1,1'b0,1'b0}, // R9
        '{4'd8, 1'b0,1'b0,1'b1, 4'h0,4'h0,4'h0, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R8 force
        '{4'd8, 1'b0,1'b0,1'b1, 4'h1,4'hF,4'h1, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R8 held
        '{4'd6, 1'b0,1'b0,1'b0, 4'h8,4'h8,4'h8, 2'd3, 1'b0,1'b1,1'b0,1'b1,1'b0}, // R6 port on top bit
        '{4'd8, 1'b0,1'b0,1'b1, 4'h0,4'h0,4'h0, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R8 cut settle
        '{4'd6, 1'b0,1'b0,1'b0, 4'h4,4'h4,4'h4, 2'd3, 1'b0,1'b1,1'b0,1'b1,1'b0}, // R6 re-wake
        '{4'd7, 1'b0,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0}, // R7 fresh window
        '{4'd7, 1'b0,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0}, // R7
        '{4'd7, 1'b0,1'b0,1'b0, 4'h0,4'h0,4'h0, 2'd0, 1'b1,1'b1,1'b1,1'b0,1'b1}  // R7 exact length
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 1'b0, stop_req = 1'b0, lv_force_stop = 1'b0;
    logic [NI-1:0] irq_req = '0, irq_en = '0, irq_port = '0;
    logic cpu_clk_en, osc_en, periph_clk_en, wdt_clr, wake_evt;
    logic [1:0] mode;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(NI), .SETTLE_CYC(SC)) u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
        .lv_force_stop(lv_force_stop), .irq_req(irq_req), .irq_en(irq_en),
        .irq_port(irq_port), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .periph_clk_en(periph_clk_en), .wdt_clr(wdt_clr), .wake_evt(wake_evt),
        .mode(mode)
    );

    function automatic logic [6:0] outs();
        return {mode, cpu_clk_en, osc_en, periph_clk_en, wdt_clr, wake_evt};
    endfunction

    task automatic check(input int rq, input logic [6:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %b expected %b", rq, outs(), exp);
        end
    endtask

    // Drive inputs at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic apply(input logic h, input logic s, input logic lv,
                         input logic [3:0] rq4, input logic [3:0] en4, input logic [3:0] pt4);
        halt_req = h; stop_req = s; lv_force_stop = lv;
        irq_req = rq4; irq_en = en4; irq_port = pt4;
        @(negedge clk);
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(1, 7'b00_111_00); // R1 state held in reset
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].h, VECS[i].s, VECS[i].lv, VECS[i].irq, VECS[i].en, VECS[i].port);
            check(int'(VECS[i].rq), {VECS[i].md, VECS[i].cpu, VECS[i].osc,
                                     VECS[i].per, VECS[i].wdt, VECS[i].wk});
        end
        // R1: a reset in light sleep returns to running with no wake pulse.
        apply(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0);
        check(2, 7'b01_011_00);
        rst_n = 1'b0;
        apply(1'b0, 1'b0, 1'b0, 4'h1, 4'h1, 4'h0);
        check(1, 7'b00_111_00);
        rst_n = 1'b1;
        // R8: force from light sleep, then hold while forced.
        apply(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0);
        apply(1'b0, 1'b0, 1'b1, 4'h1, 4'h1, 4'h0);
        check(8, 7'b10_000_00);
        // R5: after release, a non-port request does not wake.
        apply(1'b0, 1'b0, 1'b0, 4'h3, 4'h3, 4'h4);
        check(5, 7'b10_000_00);
        // R6/R7: port wake, then count the window cycle by cycle.
        apply(1'b0, 1'b0, 1'b0, 4'h4, 4'h4, 4'h4);
        check(6, 7'b11_010_10);
        for (int k = 1; k < SC; k++) begin
            apply(1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0);
            check(7, 7'b11_010_00);
        end
        apply(1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0);
        check(9, 7'b00_111_01);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule